// File: doc/BRIEF.md
# Host Transmit FIFO Port

This block carries words from a host bus into a DSP-side consumer through a write-only FIFO of 24-bit entries. A host reaches it through one of two front ends, chosen by a mode input. The first is a PCI-style target write port. It decodes a byte-offset window, places the 32-bit bus data into the entry's byte lanes according to a 2-bit format code, and uses wait states and a retry to hold off the host while the FIFO is full. The second is a simple bus port. It matches an 11-bit address against a programmed base and loads either 24 or 16 data bits. This port stalls the host for as long as the FIFO is full.

The DSP side pops words in order. The block also reports whether space is available. When software has enabled transmit requests, it raises a request status bit. That request is sent either to an interrupt line or to a DMA request line, according to a DMA-enable control. A hardware reset or a software reset empties the FIFO.

Top module: `host_tx_fifo`

## Requirements
- R1: `space_ok` is 1 whenever the FIFO holds fewer than DEPTH (default 8) words and 0 when it is full; no write is acknowledged while it is 0.
- R2: `req_stat` equals `space_ok` AND `treq_en`; while `req_stat` is 1, `irq_o` is 1 when `dma_en` is 0 and `dreq_o` is 1 when `dma_en` is 1; both are 0 otherwise.
- R3: With `mode_sel`=0 (PCI-style), a write hits the FIFO only when `pci_off` lies in 0x001C..0xFFFC inclusive; any offset in that window targets the same FIFO, and a miss gives no acknowledge and stores nothing.
- R4: PCI-style lane placement from `fmt`: 0 stores data[23:0]; 1 stores data[15:0] in the upper two bytes with a zero low byte; 2 stores data[15:0] in the lower two bytes with a zero high byte; 3 stores data[31:8].
- R5: PCI-style write to a full FIFO with `wait_dis`=0: `pci_wait` is 1 for up to 8 consecutive cycles; if space appears meanwhile, `pci_ack` follows in the next cycle; otherwise `pci_retry` is 1 in the ninth cycle and nothing is stored.
- R6: With `wait_dis`=1, a PCI-style write to a full FIFO gets `pci_retry` in its first cycle and `pci_wait` is never raised.
- R7: With `mode_sel`=1 (simple bus), a write selects the FIFO only when `sb_addr[10:3]` equals `sb_base` and `sb_addr[2:0]` is 7.
- R8: Simple-bus placement: `fmt`=0 stores all of `sb_data[23:0]`; `fmt`=1 stores `sb_data[15:0]` in the upper two bytes with a zero low byte; `fmt`=2 or 3 stores it in the lower two bytes with a zero high byte.
- R9: A simple-bus write to a full FIFO holds `sb_wait` high, with no acknowledge and no retry, until a pop frees space; it is then acknowledged in the next cycle.
- R10: `dsp_valid` is 1 when the FIFO is not empty; `dsp_data` shows the oldest word, and `dsp_pop` removes it in write order; a pop on an empty FIFO has no effect.
- R11: The port not chosen by `mode_sel` is ignored: it gives no acknowledge, wait or retry and stores nothing.
- R12: Hardware reset and a one-cycle `soft_rst` both empty the FIFO, so the next cycle shows `space_ok`=1 and `dsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous software reset, empties the FIFO |
| mode_sel | input | 1 | 0 selects the PCI-style port, 1 the simple bus port |
| fmt | input | 2 | Data format code for lane placement |
| wait_dis | input | 1 | 1 makes the PCI-style port retry at once when full |
| treq_en | input | 1 | Software enable for transmit requests |
| dma_en | input | 1 | Sends the request to `dreq_o` instead of `irq_o` |
| sb_base | input | 8 | Base address compared with `sb_addr[10:3]` |
| pci_wr | input | 1 | PCI-style write data phase valid |
| pci_off | input | 16 | Byte offset from the memory base |
| pci_data | input | 32 | PCI-style write data |
| pci_ack | output | 1 | Data phase accepted |
| pci_wait | output | 1 | Wait state inserted |
| pci_retry | output | 1 | Target retry/disconnect |
| sb_wr | input | 1 | Simple bus write strobe |
| sb_addr | input | 11 | Simple bus address |
| sb_data | input | 24 | Simple bus write data |
| sb_ack | output | 1 | Simple bus write accepted |
| sb_wait | output | 1 | Simple bus stall |
| dsp_pop | input | 1 | Remove the oldest word |
| dsp_data | output | 24 | Oldest word |
| dsp_valid | output | 1 | FIFO not empty |
| space_ok | output | 1 | FIFO can accept a word |
| req_stat | output | 1 | Transmit request status |
| irq_o | output | 1 | Interrupt request |
| dreq_o | output | 1 | DMA request |

## Verification
The hardest situation to reach is a PCI-style write that stays in wait states against a full FIFO. The bench must then either let the wait count run out into a retry, or free a slot in the middle of the count and see the acknowledge on the following cycle. The bench first fills the FIFO through the normal write path. It then holds a write data phase for a fixed number of cycles and counts wait cycles at each falling edge. On a second pass it issues a single pop partway through the wait sequence. The simple bus stall is driven the same way, and the FIFO drain that follows confirms that the stalled word landed behind the earlier ones.

// File: rtl/htx_pkg.sv
package htx_pkg;

  localparam int WORD_W = 24;

  typedef enum logic {
    HM_PCI = 1'b0,
    HM_SB  = 1'b1
  } host_mode_e;

  // PCI-style lane placement, selected by a 2-bit format code
  function automatic logic [WORD_W-1:0] pci_place(input logic [1:0] fc,
                                                  input logic [31:0] d);
    logic [WORD_W-1:0] w;
    case (fc)
      2'd0:    w = d[23:0];
      2'd1:    w = {d[15:0], 8'h00};
      2'd2:    w = {8'h00, d[15:0]};
      default: w = d[31:8];
    endcase
    return w;
  endfunction

  // simple bus placement: full word or 16 bits high/low
  function automatic logic [WORD_W-1:0] sb_place(input logic [1:0] fc,
                                                 input logic [23:0] d);
    logic [WORD_W-1:0] w;
    case (fc)
      2'd0:    w = d;
      2'd1:    w = {d[15:0], 8'h00};
      default: w = {8'h00, d[15:0]};
    endcase
    return w;
  endfunction

endpackage

// File: rtl/htx_fifo.sv
module htx_fifo
  import htx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [WORD_W-1:0] din,
  input  logic              pop,
  output logic [WORD_W-1:0] dout,
  output logic              full,
  output logic              empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0]     wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              do_push, do_pop;
  logic [WORD_W-1:0] ent [DEPTH];
  logic [DEPTH-1:0]  we;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign dout    = ent[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // one storage row per entry, each with its own write enable
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign we[i] = do_push && (wr_q == AW'(i));
    always_ff @(posedge clk) begin
      if (we[i]) ent[i] <= din;
    end
  end

endmodule

// File: rtl/htx_pci_port.sv
module htx_pci_port
  import htx_pkg::*;
#(
  parameter int          WAIT_MAX = 8,
  parameter logic [15:0] OFF_LO   = 16'h001C,
  parameter logic [15:0] OFF_HI   = 16'hFFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              wr,
  input  logic [15:0]       off,
  input  logic [31:0]       data,
  input  logic [1:0]        fc,
  input  logic              wait_dis,
  input  logic              full,
  output logic              ack,
  output logic              wait_o,
  output logic              retry,
  output logic              push,
  output logic [WORD_W-1:0] word
);

  localparam int WCW = $clog2(WAIT_MAX + 1);

  logic [WCW-1:0] wcnt_q, wcnt_d;
  logic           hit, req;

  assign hit  = (off >= OFF_LO) && (off <= OFF_HI);
  assign req  = active && wr && hit;
  assign word = pci_place(fc, data);

  always_comb begin
    ack    = 1'b0;
    wait_o = 1'b0;
    retry  = 1'b0;
    if (req) begin
      if (!full)                                       ack    = 1'b1;
      else if (wait_dis || wcnt_q == WCW'(WAIT_MAX))   retry  = 1'b1;
      else                                             wait_o = 1'b1;
    end
    push   = ack;
    wcnt_d = wait_o ? wcnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt_q <= '0;
    else        wcnt_q <= wcnt_d;
  end

endmodule

// File: rtl/htx_sb_port.sv
module htx_sb_port
  import htx_pkg::*;
(
  input  logic              active,
  input  logic              wr,
  input  logic [10:0]       addr,
  input  logic [23:0]       data,
  input  logic [1:0]        fc,
  input  logic [7:0]        base,
  input  logic              full,
  output logic              ack,
  output logic              wait_o,
  output logic              push,
  output logic [WORD_W-1:0] word
);

  logic sel;

  assign sel    = active && wr && (addr[10:3] == base) && (addr[2:0] == 3'd7);
  assign ack    = sel && !full;
  assign wait_o = sel && full;
  assign push   = ack;
  assign word   = sb_place(fc, data);

endmodule

// File: rtl/host_tx_fifo.sv
module host_tx_fifo
  import htx_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int WAIT_MAX = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        mode_sel,
  input  logic [1:0]  fmt,
  input  logic        wait_dis,
  input  logic        treq_en,
  input  logic        dma_en,
  input  logic [7:0]  sb_base,
  input  logic        pci_wr,
  input  logic [15:0] pci_off,
  input  logic [31:0] pci_data,
  output logic        pci_ack,
  output logic        pci_wait,
  output logic        pci_retry,
  input  logic        sb_wr,
  input  logic [10:0] sb_addr,
  input  logic [23:0] sb_data,
  output logic        sb_ack,
  output logic        sb_wait,
  input  logic        dsp_pop,
  output logic [23:0] dsp_data,
  output logic        dsp_valid,
  output logic        space_ok,
  output logic        req_stat,
  output logic        irq_o,
  output logic        dreq_o
);

  host_mode_e        mode;
  logic [1:0]        rsync_q, rsync_d;
  logic              rst_int_n;
  logic              full, empty;
  logic              pci_push, sb_push;
  logic [WORD_W-1:0] pci_word, sb_word, fifo_din;

  // asynchronous assertion, synchronous release
  assign rsync_d = {rsync_q[0], 1'b1};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= rsync_d;
  end
  assign rst_int_n = rsync_q[1];

  assign mode = host_mode_e'(mode_sel);

  htx_pci_port #(.WAIT_MAX(WAIT_MAX)) u_pci (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .active   (mode == HM_PCI),
    .wr       (pci_wr),
    .off      (pci_off),
    .data     (pci_data),
    .fc       (fmt),
    .wait_dis (wait_dis),
    .full     (full),
    .ack      (pci_ack),
    .wait_o   (pci_wait),
    .retry    (pci_retry),
    .push     (pci_push),
    .word     (pci_word)
  );

  htx_sb_port u_sb (
    .active (mode == HM_SB),
    .wr     (sb_wr),
    .addr   (sb_addr),
    .data   (sb_data),
    .fc     (fmt),
    .base   (sb_base),
    .full   (full),
    .ack    (sb_ack),
    .wait_o (sb_wait),
    .push   (sb_push),
    .word   (sb_word)
  );

  assign fifo_din = (mode == HM_PCI) ? pci_word : sb_word;

  htx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (soft_rst),
    .push  (pci_push || sb_push),
    .din   (fifo_din),
    .pop   (dsp_pop),
    .dout  (dsp_data),
    .full  (full),
    .empty (empty)
  );

  assign dsp_valid = !empty;
  assign space_ok  = !full;
  assign req_stat  = space_ok && treq_en;
  assign irq_o     = req_stat && !dma_en;
  assign dreq_o    = req_stat && dma_en;

endmodule

// File: rtl/host_tx_fifo_chk.sv
module host_tx_fifo_chk (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic mode_sel,
  input logic wait_dis,
  input logic pci_ack,
  input logic pci_wait,
  input logic pci_retry,
  input logic sb_ack,
  input logic sb_wait,
  input logic dsp_valid,
  input logic space_ok,
  input logic irq_o,
  input logic dreq_o
);

  p_ack_needs_space_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_ack || sb_ack) |-> space_ok);

  p_req_steer_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && dreq_o));

  p_wait_only_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pci_wait |-> (!space_ok && !pci_ack && !pci_retry));

  p_retry_after_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_retry && !wait_dis) |-> $past(pci_wait));

  p_no_wait_when_dis_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wait_dis |-> !pci_wait);

  p_sb_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sb_wait |-> (!space_ok && !sb_ack && !pci_retry));

  p_pci_mode_quiet_sb_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_sel |-> (!sb_ack && !sb_wait));

  p_sb_mode_quiet_pci_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel |-> (!pci_ack && !pci_wait && !pci_retry));

  p_soft_reset_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (space_ok && !dsp_valid));

endmodule

bind host_tx_fifo host_tx_fifo_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .soft_rst  (soft_rst),
  .mode_sel  (mode_sel),
  .wait_dis  (wait_dis),
  .pci_ack   (pci_ack),
  .pci_wait  (pci_wait),
  .pci_retry (pci_retry),
  .sb_ack    (sb_ack),
  .sb_wait   (sb_wait),
  .dsp_valid (dsp_valid),
  .space_ok  (space_ok),
  .irq_o     (irq_o),
  .dreq_o    (dreq_o)
);

// File: tb/host_tx_fifo_bench.sv
module host_tx_fifo_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int NV         = 12;

  // {mode, fmt, addr[15:0], data[31:0], hit, expected[23:0]}
  localparam logic [75:0] VEC [NV] = '{
    {1'b0, 2'd0, 16'h001C, 32'hAABBCCDD, 1'b1, 24'hBBCCDD},
    {1'b0, 2'd1, 16'h0020, 32'h11223344, 1'b1, 24'h334400},
    {1'b0, 2'd2, 16'hFFFC, 32'h11223344, 1'b1, 24'h003344},
    {1'b0, 2'd3, 16'h0100, 32'hDEADBEEF, 1'b1, 24'hDEADBE},
    {1'b0, 2'd0, 16'h0018, 32'h12345678, 1'b0, 24'h000000},
    {1'b0, 2'd0, 16'hFFFE, 32'h12345678, 1'b0, 24'h000000},
    {1'b1, 2'd0, 16'h02D7, 32'h00123456, 1'b1, 24'h123456},
    {1'b1, 2'd1, 16'h02D7, 32'h0000ABCD, 1'b1, 24'hABCD00},
    {1'b1, 2'd2, 16'h02D7, 32'h00FFABCD, 1'b1, 24'h00ABCD},
    {1'b1, 2'd3, 16'h02D7, 32'h00FFABCD, 1'b1, 24'h00ABCD},
    {1'b1, 2'd0, 16'h02D6, 32'h00777777, 1'b0, 24'h000000},
    {1'b1, 2'd0, 16'h02DF, 32'h00777777, 1'b0, 24'h000000}
  };

  logic        clk = 1'b0;
  logic        rst_n, soft_rst, mode_sel, wait_dis, treq_en, dma_en;
  logic [1:0]  fmt;
  logic [7:0]  sb_base;
  logic        pci_wr, pci_ack, pci_wait, pci_retry;
  logic [15:0] pci_off;
  logic [31:0] pci_data;
  logic        sb_wr, sb_ack, sb_wait;
  logic [10:0] sb_addr;
  logic [23:0] sb_data, dsp_data;
  logic        dsp_pop, dsp_valid, space_ok, req_stat, irq_o, dreq_o;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_tx_fifo #(.DEPTH(DEPTH)) u_host_tx_fifo (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .mode_sel(mode_sel),
    .fmt(fmt), .wait_dis(wait_dis), .treq_en(treq_en), .dma_en(dma_en),
    .sb_base(sb_base), .pci_wr(pci_wr), .pci_off(pci_off),
    .pci_data(pci_data), .pci_ack(pci_ack), .pci_wait(pci_wait),
    .pci_retry(pci_retry), .sb_wr(sb_wr), .sb_addr(sb_addr),
    .sb_data(sb_data), .sb_ack(sb_ack), .sb_wait(sb_wait),
    .dsp_pop(dsp_pop), .dsp_data(dsp_data), .dsp_valid(dsp_valid),
    .space_ok(space_ok), .req_stat(req_stat), .irq_o(irq_o), .dreq_o(dreq_o)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog expired act=0 exp=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; mode_sel = 1'b0; wait_dis = 1'b0;
    treq_en = 1'b1; dma_en = 1'b0; fmt = 2'd0; sb_base = 8'h5A;
    pci_wr = 1'b0; pci_off = '0; pci_data = '0;
    sb_wr = 1'b0; sb_addr = '0; sb_data = '0; dsp_pop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state: R1 R2 R12
    #1;
    chk("R12 reset empty", dsp_valid, 0);
    chk("R1 reset space", space_ok, 1);
    chk("R2 irq steer", {req_stat, irq_o, dreq_o}, 3'b110);

    // table of vectors: R3 R4 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [75:0] v;
      v = VEC[i];
      @(negedge clk);
      mode_sel = v[75];
      fmt      = v[74:73];
      if (!v[75]) begin
        pci_wr = 1'b1; pci_off = v[72:57]; pci_data = v[56:25];
      end else begin
        sb_wr = 1'b1; sb_addr = v[67:57]; sb_data = v[48:25];
      end
      #1;
      if (!v[75]) chk("R3 pci decode ack", pci_ack, v[24]);
      else        chk("R7 sb decode ack", sb_ack, v[24]);
      @(negedge clk);
      pci_wr = 1'b0; sb_wr = 1'b0;
      #1;
      chk(v[75] ? "R7 sb stored" : "R3 pci stored", dsp_valid, v[24]);
      if (v[24]) chk(v[75] ? "R8 sb lanes" : "R4 pci lanes", dsp_data, v[23:0]);
      dsp_pop = v[24];
      @(negedge clk);
      dsp_pop = 1'b0;
    end

    // R11: inactive port ignored
    @(negedge clk);
    mode_sel = 1'b1; pci_wr = 1'b1; pci_off = 16'h001C; pci_data = 32'h1;
    #1 chk("R11 pci ignored in sb mode", {pci_ack, pci_wait, pci_retry}, 0);
    @(negedge clk);
    pci_wr = 1'b0; mode_sel = 1'b0; sb_wr = 1'b1; sb_addr = 11'h2D7;
    #1 chk("R11 sb ignored in pci mode", {sb_ack, sb_wait}, 0);
    @(negedge clk);
    sb_wr = 1'b0;
    #1 chk("R11 nothing stored", dsp_valid, 0);

    // R10: pop on empty does nothing
    dsp_pop = 1'b1;
    @(negedge clk);
    dsp_pop = 1'b0;
    #1 chk("R10 empty pop", {dsp_valid, space_ok}, 2'b01);

    // fill through simple bus
    mode_sel = 1'b1; fmt = 2'd0; sb_addr = 11'h2D7;
    for (int k = 0; k < DEPTH; k++) begin
      sb_wr = 1'b1; sb_data = 24'h100 + 24'(k);
      #1 chk("R1 accepts while space", sb_ack, 1);
      @(negedge clk);
    end
    sb_wr = 1'b0;
    #1;
    chk("R1 full clears space", space_ok, 0);
    chk("R2 no request when full", {req_stat, irq_o, dreq_o}, 0);

    // R9: stall on full, no retry
    sb_wr = 1'b1; sb_data = 24'hABCDEF;
    for (int k = 0; k < 3; k++) begin
      #1 chk("R9 sb stalls", {sb_wait, sb_ack, pci_retry}, 3'b100);
      @(negedge clk);
    end
    #1 chk("R10 oldest first", dsp_data, 24'h100);
    dsp_pop = 1'b1;
    @(negedge clk);
    dsp_pop = 1'b0;
    #1 chk("R9 ack after pop", {sb_ack, sb_wait}, 2'b10);
    @(negedge clk);
    sb_wr = 1'b0;

    // R10: drain in order
    for (int k = 1; k <= DEPTH; k++) begin
      #1 chk("R10 order", dsp_data, (k == DEPTH) ? 24'hABCDEF : 24'h100 + 24'(k));
      dsp_pop = 1'b1;
      @(negedge clk);
    end
    dsp_pop = 1'b0;
    #1 chk("R10 drained", dsp_valid, 0);

    // fill through PCI-style port
    mode_sel = 1'b0; fmt = 2'd0; pci_off = 16'h0040;
    for (int k = 0; k < DEPTH; k++) begin
      pci_wr = 1'b1; pci_data = 32'h200 + 32'(k);
      #1 chk("R1 pci accepts while space", pci_ack, 1);
      @(negedge clk);
    end
    pci_wr = 1'b0;
    @(negedge clk);

    // R5: eight waits then retry
    pci_wr = 1'b1; pci_data = 32'h555;
    for (int w = 0; w < 8; w++) begin
      #1 chk("R5 wait state", {pci_wait, pci_ack, pci_retry}, 3'b100);
      @(negedge clk);
    end
    #1 chk("R5 retry after eight", {pci_retry, pci_wait, pci_ack}, 3'b100);
    @(negedge clk);
    pci_wr = 1'b0;
    @(negedge clk);

    // R5: space freed during waits
    pci_wr = 1'b1; pci_data = 32'h666;
    for (int w = 0; w < 3; w++) begin
      #1 chk("R5 wait before pop", pci_wait, 1);
      @(negedge clk);
    end
    dsp_pop = 1'b1;
    @(negedge clk);
    dsp_pop = 1'b0;
    #1 chk("R5 ack after space", {pci_ack, pci_wait, pci_retry}, 3'b100);
    @(negedge clk);
    pci_wr = 1'b0;

    // R6: waits disabled gives immediate retry
    wait_dis = 1'b1; pci_wr = 1'b1;
    #1 chk("R6 immediate retry", {pci_retry, pci_wait}, 2'b10);
    @(negedge clk);
    pci_wr = 1'b0; wait_dis = 1'b0;

    // R12: software reset empties a full FIFO
    #1 chk("R12 full before soft reset", space_ok, 0);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    #1 chk("R12 soft reset empties", {space_ok, dsp_valid}, 2'b10);

    // R2: DMA steering and enable
    dma_en = 1'b1;
    #1 chk("R2 dma steer", {req_stat, irq_o, dreq_o}, 3'b101);
    treq_en = 1'b0;
    #1 chk("R2 request disabled", {req_stat, irq_o, dreq_o}, 0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule